// File: doc/BRIEF.md
# Slotted Ring Station

This block is one station on a one-way slotted ring that joins agents such as cores, cache slices, a system agent and a graphics unit. The ring is built from four sub-rings that run side by side and never interact: a 32-byte data ring and three control rings for requests, acknowledges and snoops. Every clock, each station takes the slot arriving from upstream, keeps it, clears it or fills it, and passes it on through one register stage.

Arbitration is purely local. A station fills a slot only when that slot arrives empty, or when the station is itself emptying it by taking out a packet addressed to it. No central arbiter exists. A cache line of 64 bytes crosses the data ring as two halves. Each half needs its own free slot, and the two slots need not be back to back. The receiving station rebuilds the line from the half-index bit of each slot.

Toward the local agent, each sub-ring has a four-entry transmit queue with a valid/ready interface. A word moves on a clock edge where both valid and ready are high. Ready falls while the queue holds four entries, and the agent must then keep its word until ready returns. Received packets and lines are handed out as one-cycle valid pulses with no ready. The agent must take them in the cycle they appear, because the ring cannot stall.

Top module: `ring_stop`

## Requirements
- R1: A valid slot whose destination is not this station leaves on the ring output unchanged one clock after it arrives.
- R2: A valid slot whose destination equals STOP_ID is removed. One clock later the ring output carries no valid slot unless R4 applies, and for a control ring the rx valid pulses for one cycle with the slot's source and payload.
- R3: A queued packet enters only a slot that arrives empty. While occupied through-traffic passes, the packet waits at the queue head. When it is sent, the output slot carries the queue's destination, source STOP_ID and the queued payload.
- R4: A slot emptied by ejection can be refilled by this station in the same cycle, so the ring output shows the local packet one clock later.
- R5: A line is split into half 0 (bits 255:0, index bit 0) and half 1 (bits 511:256, index bit 1), sent in that order. Each half takes its own empty slot, and occupied slots between the two halves are passed through.
- R6: The receiver keeps halves per source by index bit, in either arrival order. It pulses line_rx_valid with source and full line one clock after the slot that completes the line; halves from different sources may interleave.
- R7: Each transmit queue holds up to four entries in FIFO order. Ready is low while four are held, and a word offered while ready is low is not taken.
- R8: The four sub-rings are independent: traffic or injection on one never changes another's output.
- R9: Slot layout from most significant bit: valid, destination ID (3 bits), source ID (3 bits), index bit, payload. Control rings always carry index 0. After reset, all ring outputs are empty, all rx valids low, and all tx readys high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_ring_i | input | 264 | Data ring slot from upstream |
| dat_ring_o | output | 264 | Data ring slot to downstream |
| ctl_ring_i | input | 3x72 | Control ring slots from upstream (0 request, 1 acknowledge, 2 snoop) |
| ctl_ring_o | output | 3x72 | Control ring slots to downstream |
| line_tx_valid | input | 1 | Line offered for sending |
| line_tx_ready | output | 1 | Line queue can accept |
| line_tx_dst | input | 3 | Destination station of the line |
| line_tx_data | input | 512 | Line to send |
| line_rx_valid | output | 1 | Received line complete (one-cycle pulse) |
| line_rx_src | output | 3 | Source station of the received line |
| line_rx_data | output | 512 | Reassembled line |
| ctl_tx_valid | input | 3 | Control packet offered, one bit per control ring |
| ctl_tx_ready | output | 3 | Control queue can accept, one bit per control ring |
| ctl_tx_dst | input | 3x3 | Destination station per control ring |
| ctl_tx_data | input | 3x64 | Payload per control ring |
| ctl_rx_valid | output | 3 | Control packet received (one-cycle pulse) |
| ctl_rx_src | output | 3x3 | Source station of received control packet |
| ctl_rx_data | output | 3x64 | Payload of received control packet |

## Verification
Through-traffic and ejection results are due one clock after the slot is driven, because the station adds one register stage. A control rx pulse and a completed line appear in that same cycle. A queued packet shows on the ring two clocks after its handshake if the next arriving slot is free, and the second half of a line one clock later for each occupied slot in between. The bench drives every input just after a falling edge and samples exactly one falling edge later per stage counted, so each check lands in the cycle its result is due.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int NUM_CTL = 3;
  typedef enum int {
    CTL_REQ = 0,
    CTL_ACK = 1,
    CTL_SNP = 2
  } ctl_lane_e;
endpackage

// File: rtl/ring_txq.sv
module ring_txq #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          push, pop;

  assign in_ready  = (cnt_q != (AW+1)'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= in_data;
  end

  // R7: the head entry holds still until it is taken
  p_hold_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/ring_slot_stage.sv
module ring_slot_stage #(
  parameter int ID_W    = 3,
  parameter int PW      = 64,
  parameter int BEATS   = 1,
  parameter int STOP_ID = 0,
  localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int SW     = 1 + 2*ID_W + BW + PW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SW-1:0]       slot_i,
  output logic [SW-1:0]       slot_o,
  input  logic                head_valid,
  input  logic [ID_W-1:0]     head_dst,
  input  logic [BEATS*PW-1:0] head_data,
  output logic                head_pop,
  output logic                ej_valid,
  output logic [ID_W-1:0]     ej_src,
  output logic [BW-1:0]       ej_idx,
  output logic [PW-1:0]       ej_data
);
  localparam logic [ID_W-1:0] MY_ID    = ID_W'(STOP_ID);
  localparam logic [BW-1:0]   LAST_BT  = BW'(BEATS - 1);

  logic            in_v, hit, free, inject;
  logic [ID_W-1:0] in_dst, in_src;
  logic [BW-1:0]   beat_q;
  logic [SW-1:0]   nxt_slot;

  always_comb begin
    in_v     = slot_i[SW-1];
    in_dst   = slot_i[SW-2 -: ID_W];
    in_src   = slot_i[SW-2-ID_W -: ID_W];
    hit      = in_v && (in_dst == MY_ID);
    free     = !in_v || hit;
    inject   = free && head_valid;
    head_pop = inject && (beat_q == LAST_BT);
    if (inject)
      nxt_slot = {1'b1, head_dst, MY_ID, beat_q, head_data[int'(beat_q)*PW +: PW]};
    else if (hit)
      nxt_slot = '0;
    else
      nxt_slot = slot_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_o   <= '0;
      beat_q   <= '0;
      ej_valid <= 1'b0;
      ej_src   <= '0;
      ej_idx   <= '0;
      ej_data  <= '0;
    end else begin
      slot_o   <= nxt_slot;
      ej_valid <= hit;
      if (hit) begin
        ej_src  <= in_src;
        ej_idx  <= slot_i[PW +: BW];
        ej_data <= slot_i[PW-1:0];
      end
      if (inject) beat_q <= (beat_q == LAST_BT) ? '0 : beat_q + 1'b1;
    end
  end

  // R1: through-traffic is forwarded untouched
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && !hit) |=> (slot_o == $past(slot_i)));
  // R2: a packet for this station is handed to the agent
  p_eject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (ej_valid && ej_src == $past(in_src) && ej_data == $past(slot_i[PW-1:0])));
  // R3: nothing appears without a queued packet
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_v && !head_valid) |=> !slot_o[SW-1]);
  // R4: an ejected slot is refilled when a packet waits
  p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && head_valid) |=> (slot_o[SW-1] && slot_o[SW-2-ID_W -: ID_W] == MY_ID));
endmodule

// File: rtl/ring_line_asm.sv
module ring_line_asm #(
  parameter int ID_W   = 3,
  parameter int DATA_W = 256,
  parameter int BEATS  = 2,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int NSRC  = 1 << ID_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ej_valid,
  input  logic [ID_W-1:0]         ej_src,
  input  logic [BW-1:0]           ej_idx,
  input  logic [DATA_W-1:0]       ej_data,
  output logic                    line_valid,
  output logic [ID_W-1:0]         line_src,
  output logic [BEATS*DATA_W-1:0] line_data
);
  logic [DATA_W-1:0] buf_q  [NSRC][BEATS];
  logic [BEATS-1:0]  have_q [NSRC];
  logic [BEATS-1:0]  mask_now;

  always_comb begin
    mask_now   = have_q[ej_src] | (BEATS'(1) << ej_idx);
    line_valid = ej_valid && (&mask_now);
    line_src   = ej_src;
    for (int j = 0; j < BEATS; j++)
      line_data[j*DATA_W +: DATA_W] = (BW'(j) == ej_idx) ? ej_data : buf_q[ej_src][j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) have_q[s] <= '0;
    end else if (ej_valid) begin
      have_q[ej_src] <= line_valid ? '0 : mask_now;
    end
  end

  always_ff @(posedge clk) begin
    if (ej_valid) buf_q[ej_src][ej_idx] <= ej_data;
  end
endmodule

// File: rtl/ring_stop.sv
module ring_stop
  import ring_pkg::*;
#(
  parameter int ID_W       = 3,
  parameter int DATA_W     = 256,
  parameter int CTRL_W     = 64,
  parameter int LINE_BEATS = 2,
  parameter int QDEPTH     = 4,
  parameter int STOP_ID    = 3,
  localparam int IDX_W     = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1,
  localparam int DSW       = 1 + 2*ID_W + IDX_W + DATA_W,
  localparam int CSW       = 1 + 2*ID_W + 1 + CTRL_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [DSW-1:0]                     dat_ring_i,
  output logic [DSW-1:0]                     dat_ring_o,
  input  logic [NUM_CTL-1:0][CSW-1:0]        ctl_ring_i,
  output logic [NUM_CTL-1:0][CSW-1:0]        ctl_ring_o,
  input  logic                               line_tx_valid,
  output logic                               line_tx_ready,
  input  logic [ID_W-1:0]                    line_tx_dst,
  input  logic [LINE_BEATS*DATA_W-1:0]       line_tx_data,
  output logic                               line_rx_valid,
  output logic [ID_W-1:0]                    line_rx_src,
  output logic [LINE_BEATS*DATA_W-1:0]       line_rx_data,
  input  logic [NUM_CTL-1:0]                 ctl_tx_valid,
  output logic [NUM_CTL-1:0]                 ctl_tx_ready,
  input  logic [NUM_CTL-1:0][ID_W-1:0]       ctl_tx_dst,
  input  logic [NUM_CTL-1:0][CTRL_W-1:0]     ctl_tx_data,
  output logic [NUM_CTL-1:0]                 ctl_rx_valid,
  output logic [NUM_CTL-1:0][ID_W-1:0]       ctl_rx_src,
  output logic [NUM_CTL-1:0][CTRL_W-1:0]     ctl_rx_data
);
  localparam int LW  = LINE_BEATS * DATA_W;
  localparam int DQW = ID_W + LW;
  localparam int CQW = ID_W + CTRL_W;

  // data ring: line queue, two-beat stage, reassembly
  logic              dq_valid, dq_pop;
  logic [DQW-1:0]    dq_head;
  logic              dej_valid;
  logic [ID_W-1:0]   dej_src;
  logic [IDX_W-1:0]  dej_idx;
  logic [DATA_W-1:0] dej_data;

  ring_txq #(.W(DQW), .DEPTH(QDEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(line_tx_valid), .in_ready(line_tx_ready),
    .in_data({line_tx_dst, line_tx_data}),
    .out_valid(dq_valid), .out_ready(dq_pop), .out_data(dq_head));

  ring_slot_stage #(.ID_W(ID_W), .PW(DATA_W), .BEATS(LINE_BEATS), .STOP_ID(STOP_ID)) u_dstage (
    .clk(clk), .rst_n(rst_n),
    .slot_i(dat_ring_i), .slot_o(dat_ring_o),
    .head_valid(dq_valid), .head_dst(dq_head[DQW-1 -: ID_W]), .head_data(dq_head[LW-1:0]),
    .head_pop(dq_pop),
    .ej_valid(dej_valid), .ej_src(dej_src), .ej_idx(dej_idx), .ej_data(dej_data));

  ring_line_asm #(.ID_W(ID_W), .DATA_W(DATA_W), .BEATS(LINE_BEATS)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .ej_valid(dej_valid), .ej_src(dej_src), .ej_idx(dej_idx), .ej_data(dej_data),
    .line_valid(line_rx_valid), .line_src(line_rx_src), .line_data(line_rx_data));

  // control rings: one single-beat lane each
  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    logic           cq_valid, cq_pop;
    logic [CQW-1:0] cq_head;
    logic [0:0]     cej_idx;

    ring_txq #(.W(CQW), .DEPTH(QDEPTH)) u_cq (
      .clk(clk), .rst_n(rst_n),
      .in_valid(ctl_tx_valid[g]), .in_ready(ctl_tx_ready[g]),
      .in_data({ctl_tx_dst[g], ctl_tx_data[g]}),
      .out_valid(cq_valid), .out_ready(cq_pop), .out_data(cq_head));

    ring_slot_stage #(.ID_W(ID_W), .PW(CTRL_W), .BEATS(1), .STOP_ID(STOP_ID)) u_cstage (
      .clk(clk), .rst_n(rst_n),
      .slot_i(ctl_ring_i[g]), .slot_o(ctl_ring_o[g]),
      .head_valid(cq_valid), .head_dst(cq_head[CQW-1 -: ID_W]), .head_data(cq_head[CTRL_W-1:0]),
      .head_pop(cq_pop),
      .ej_valid(ctl_rx_valid[g]), .ej_src(ctl_rx_src[g]), .ej_idx(cej_idx), .ej_data(ctl_rx_data[g]));

    // R9: single-beat rings never deliver a nonzero index
    p_ctl_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rx_valid[g] |-> (cej_idx == 1'b0));
  end
endmodule

// File: tb/ring_stop_tb.sv
module ring_stop_tb;
  localparam int ID_W = 3, CW = 64, DW = 256, ME = 3;
  localparam int CSW = 1 + 2*ID_W + 1 + CW;
  localparam int DSW = 1 + 2*ID_W + 1 + DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DSW-1:0] dat_ring_i, dat_ring_o;
  logic [2:0][CSW-1:0] ctl_ring_i, ctl_ring_o;
  logic line_tx_valid, line_tx_ready, line_rx_valid;
  logic [ID_W-1:0] line_tx_dst, line_rx_src;
  logic [2*DW-1:0] line_tx_data, line_rx_data;
  logic [2:0] ctl_tx_valid, ctl_tx_ready, ctl_rx_valid;
  logic [2:0][ID_W-1:0] ctl_tx_dst, ctl_rx_src;
  logic [2:0][CW-1:0] ctl_tx_data, ctl_rx_data;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ring_stop u_dut (
    .clk(clk), .rst_n(rst_n),
    .dat_ring_i(dat_ring_i), .dat_ring_o(dat_ring_o),
    .ctl_ring_i(ctl_ring_i), .ctl_ring_o(ctl_ring_o),
    .line_tx_valid(line_tx_valid), .line_tx_ready(line_tx_ready),
    .line_tx_dst(line_tx_dst), .line_tx_data(line_tx_data),
    .line_rx_valid(line_rx_valid), .line_rx_src(line_rx_src), .line_rx_data(line_rx_data),
    .ctl_tx_valid(ctl_tx_valid), .ctl_tx_ready(ctl_tx_ready),
    .ctl_tx_dst(ctl_tx_dst), .ctl_tx_data(ctl_tx_data),
    .ctl_rx_valid(ctl_rx_valid), .ctl_rx_src(ctl_rx_src), .ctl_rx_data(ctl_rx_data));

  function automatic logic [CSW-1:0] cs(logic v, logic [2:0] d, logic [2:0] s, logic [CW-1:0] p);
    return {v, d, s, 1'b0, p};
  endfunction
  function automatic logic [DSW-1:0] ds(logic v, logic [2:0] d, logic [2:0] s, logic i, logic [DW-1:0] p);
    return {v, d, s, i, p};
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  // vectors on the request ring: {valid, dst, src, payload8, exp_out_valid, exp_rx}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 3'd5, 3'd1, 8'hA1, 1'b1, 1'b0},
    {1'b1, 3'd3, 3'd2, 8'hB2, 1'b0, 1'b1},
    {1'b0, 3'd3, 3'd0, 8'h00, 1'b0, 1'b0},
    {1'b1, 3'd0, 3'd7, 8'hC3, 1'b1, 1'b0},
    {1'b1, 3'd3, 3'd7, 8'hD4, 1'b0, 1'b1},
    {1'b1, 3'd7, 3'd3, 8'hE5, 1'b1, 1'b0},
    {1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0},
    {1'b1, 3'd3, 3'd3, 8'hF6, 1'b0, 1'b1}
  };

  initial begin
    dat_ring_i = '0; ctl_ring_i = '0;
    line_tx_valid = 1'b0; line_tx_dst = '0; line_tx_data = '0;
    ctl_tx_valid = '0; ctl_tx_dst = '0; ctl_tx_data = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset data ring empty", 512'(dat_ring_o[DSW-1]), 512'd0);
    chk("R9 reset ctl rings empty", 512'({ctl_ring_o[2][CSW-1], ctl_ring_o[1][CSW-1], ctl_ring_o[0][CSW-1]}), 512'd0);
    chk("R9 reset rx idle", 512'({line_rx_valid, ctl_rx_valid}), 512'd0);
    chk("R9 reset tx ready", 512'({line_tx_ready, ctl_tx_ready}), 512'hF);
    rst_n = 1'b1;

    // R1/R2 vector walk
    for (int i = 0; i < 8; i++) begin
      ctl_ring_i[0] = cs(VEC[i][16], VEC[i][15:13], VEC[i][12:10], CW'(VEC[i][9:2]));
      @(negedge clk);
      chk("R1 out valid", 512'(ctl_ring_o[0][CSW-1]), 512'(VEC[i][1]));
      if (VEC[i][1]) chk("R1 passthrough slot", 512'(ctl_ring_o[0]), 512'(cs(1'b1, VEC[i][15:13], VEC[i][12:10], CW'(VEC[i][9:2]))));
      chk("R2 rx valid", 512'(ctl_rx_valid[0]), 512'(VEC[i][0]));
      if (VEC[i][0]) chk("R2 rx src/data", 512'({ctl_rx_src[0], ctl_rx_data[0]}), 512'({VEC[i][12:10], CW'(VEC[i][9:2])}));
      chk("R8 other rings quiet", 512'({ctl_ring_o[2][CSW-1], ctl_ring_o[1][CSW-1], dat_ring_o[DSW-1]}), 512'd0);
    end
    ctl_ring_i = '0;
    @(negedge clk);

    // R3 inject into empty slot
    ctl_tx_valid[0] = 1'b1; ctl_tx_dst[0] = 3'd6; ctl_tx_data[0] = 64'h1111;
    @(negedge clk); ctl_tx_valid[0] = 1'b0;
    @(negedge clk);
    chk("R3 inject empty", 512'(ctl_ring_o[0]), 512'(cs(1'b1, 3'd6, 3'(ME), 64'h1111)));
    @(negedge clk);
    chk("R3 single send", 512'(ctl_ring_o[0][CSW-1]), 512'd0);

    // R3 blocked by through-traffic
    ctl_tx_valid[0] = 1'b1; ctl_tx_data[0] = 64'h2222;
    @(negedge clk); ctl_tx_valid[0] = 1'b0; ctl_ring_i[0] = cs(1'b1, 3'd5, 3'd1, 64'hAAAA);
    @(negedge clk);
    chk("R3 busy slot kept", 512'(ctl_ring_o[0]), 512'(cs(1'b1, 3'd5, 3'd1, 64'hAAAA)));
    ctl_ring_i[0] = '0;
    @(negedge clk);
    chk("R3 sent after wait", 512'(ctl_ring_o[0]), 512'(cs(1'b1, 3'd6, 3'(ME), 64'h2222)));

    // R4 refill of an ejected slot
    ctl_tx_valid[0] = 1'b1; ctl_tx_data[0] = 64'h3333;
    @(negedge clk); ctl_tx_valid[0] = 1'b0; ctl_ring_i[0] = cs(1'b1, 3'(ME), 3'd4, 64'hBBBB);
    @(negedge clk);
    chk("R4 refilled slot", 512'(ctl_ring_o[0]), 512'(cs(1'b1, 3'd6, 3'(ME), 64'h3333)));
    chk("R4 eject alongside", 512'({ctl_rx_valid[0], ctl_rx_src[0], ctl_rx_data[0]}), 512'({1'b1, 3'd4, 64'hBBBB}));
    ctl_ring_i[0] = '0;
    @(negedge clk);

    // R7 queue full and FIFO order
    ctl_ring_i[0] = cs(1'b1, 3'd5, 3'd1, 64'h0);
    for (int k = 0; k < 4; k++) begin
      ctl_tx_valid[0] = 1'b1; ctl_tx_data[0] = 64'(16 + k);
      @(negedge clk);
    end
    chk("R7 ready low when full", 512'(ctl_tx_ready[0]), 512'd0);
    ctl_tx_data[0] = 64'h99;
    @(negedge clk);
    ctl_tx_valid[0] = 1'b0;
    chk("R7 still full", 512'(ctl_tx_ready[0]), 512'd0);
    ctl_ring_i[0] = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 drain order", 512'(ctl_ring_o[0]), 512'(cs(1'b1, 3'd6, 3'(ME), 64'(16 + k))));
    end
    @(negedge clk);
    chk("R7 refused word not sent", 512'(ctl_ring_o[0][CSW-1]), 512'd0);

    // R5 line split with a busy slot between halves
    line_tx_valid = 1'b1; line_tx_dst = 3'd1; line_tx_data = {256'h5678, 256'h1234};
    @(negedge clk); line_tx_valid = 1'b0;
    @(negedge clk);
    chk("R5 half 0", 512'(dat_ring_o), 512'(ds(1'b1, 3'd1, 3'(ME), 1'b0, 256'h1234)));
    dat_ring_i = ds(1'b1, 3'd6, 3'd2, 1'b0, 256'h777);
    @(negedge clk);
    chk("R5 busy slot between", 512'(dat_ring_o), 512'(ds(1'b1, 3'd6, 3'd2, 1'b0, 256'h777)));
    dat_ring_i = '0;
    @(negedge clk);
    chk("R5 half 1", 512'(dat_ring_o), 512'(ds(1'b1, 3'd1, 3'(ME), 1'b1, 256'h5678)));

    // R6 reassembly with interleaved sources and reversed order
    dat_ring_i = ds(1'b1, 3'(ME), 3'd5, 1'b0, 256'hA0);
    @(negedge clk);
    chk("R6 no line after one half", 512'(line_rx_valid), 512'd0);
    chk("R2 data slot removed", 512'(dat_ring_o[DSW-1]), 512'd0);
    dat_ring_i = ds(1'b1, 3'(ME), 3'd6, 1'b1, 256'hB1);
    @(negedge clk);
    chk("R6 no line after upper half", 512'(line_rx_valid), 512'd0);
    dat_ring_i = ds(1'b1, 3'(ME), 3'd6, 1'b0, 256'hB0);
    @(negedge clk);
    chk("R6 line src 6", 512'({line_rx_valid, line_rx_src}), 512'({1'b1, 3'd6}));
    chk("R6 line data 6", line_rx_data, {256'hB1, 256'hB0});
    dat_ring_i = ds(1'b1, 3'(ME), 3'd5, 1'b1, 256'hA1);
    @(negedge clk);
    chk("R6 line src 5", 512'({line_rx_valid, line_rx_src}), 512'({1'b1, 3'd5}));
    chk("R6 line data 5", line_rx_data, {256'hA1, 256'hA0});
    dat_ring_i = '0;
    @(negedge clk);
    chk("R6 pulse ends", 512'(line_rx_valid), 512'd0);

    // R8 injection on acknowledge ring while request ring busy
    ctl_tx_valid[1] = 1'b1; ctl_tx_dst[1] = 3'd2; ctl_tx_data[1] = 64'h4444;
    @(negedge clk); ctl_tx_valid[1] = 1'b0; ctl_ring_i[0] = cs(1'b1, 3'd5, 3'd1, 64'hCCCC);
    @(negedge clk);
    chk("R8 ack ring injects", 512'(ctl_ring_o[1]), 512'(cs(1'b1, 3'd2, 3'(ME), 64'h4444)));
    chk("R8 request ring untouched", 512'(ctl_ring_o[0]), 512'(cs(1'b1, 3'd5, 3'd1, 64'hCCCC)));
    chk("R8 snoop and data quiet", 512'({ctl_ring_o[2][CSW-1], dat_ring_o[DSW-1]}), 512'd0);
    ctl_ring_i = '0;
    @(negedge clk);
    wrap_up();
  end
endmodule